// File: doc/BRIEF.md
# Lockstep Divergence and Timing-Leak Monitor

This block sits beside two identical copies of a processor core that are clocked together, leave reset on the same edge, and run one program on two different secret inputs. Every cycle it compares a chosen set of mirrored state values and the register-file write ports of the two copies. It produces a registered divergence vector with one bit per compared item. The vector from the cycle before is also exported so that downstream coverage logic can hash transitions between divergence patterns.

The monitor also counts cycles for each copy until that copy raises its termination flag. When both copies have finished, it raises a leak flag if their cycle counts differ, because the cycle count is what the attacker can observe. If either copy has not finished within a parameterised cycle limit, the run ends with a hang flag instead. A write port's compare ignores address and data when neither copy is writing, so values on idle or speculative ports do not set divergence bits.

Top module: `lockstep_div_mon`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, div_q, div_prev, done, leak and hang are all 0.
- R2: Bit i of div_q (i below NSIG) is 1 in the cycle after the edge at which the i-th SW-bit slices of st_a and st_b differ, and 0 when they are equal.
- R3: Bit NSIG+p of div_q is 1 after an edge at which wv_a[p] and wv_b[p] differ.
- R4: When wv_a[p] and wv_b[p] are both 1, bit NSIG+p is 1 exactly when the port's AW-bit addresses or DW-bit data differ. When both are 0, the bit is 0 whatever the addresses and data are.
- R5: div_prev always equals the value div_q held one cycle earlier.
- R6: A copy whose term input is first sampled high at the n-th rising edge after reset release records a count of n. done rises after the edge at which the second copy's flag is sampled.
- R7: With both copies finished, leak is 1 exactly when the two recorded counts differ.
- R8: Term pulses after a copy's first one are ignored and do not change its recorded count.
- R9: If a copy has not sampled its term flag by edge TMO, hang and done rise after that edge and leak stays 0. A flag sampled exactly at edge TMO still counts as a normal finish.
- R10: Once done is 1 it stays 1, and leak and hang hold their values, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with both core copies |
| rst_n | input | 1 | Active-low reset shared with both copies |
| st_a | input | NSIG*SW | Mirrored state slices, copy A |
| st_b | input | NSIG*SW | Mirrored state slices, copy B |
| wv_a | input | NPORT | Register-write valid per port, copy A |
| wv_b | input | NPORT | Register-write valid per port, copy B |
| wa_a | input | NPORT*AW | Register-write addresses, copy A |
| wa_b | input | NPORT*AW | Register-write addresses, copy B |
| wd_a | input | NPORT*DW | Register-write data, copy A |
| wd_b | input | NPORT*DW | Register-write data, copy B |
| term_a | input | 1 | Termination flag of copy A, polled every cycle |
| term_b | input | 1 | Termination flag of copy B, polled every cycle |
| div_q | output | NSIG+NPORT | Registered divergence vector |
| div_prev | output | NSIG+NPORT | Divergence vector of the previous cycle |
| done | output | 1 | Both copies finished, or the limit expired |
| leak | output | 1 | Cycle counts of the two copies differ |
| hang | output | 1 | A copy failed to finish within TMO cycles |

## Verification
The bench targets write ports where neither copy is writing but addresses and data differ. A design that compared those fields without checking valid would report false divergence there. It sends a second term pulse to a copy that has already finished, timed so that the counts match only if the pulse is wrongly taken; a counter that restarted or kept counting would then hide a real leak. It also tests the limit edge, with one copy finishing exactly at cycle TMO, where an off-by-one comparison would flag a hang on a good run. Runs where one copy or both never finish must end with hang and without leak. Sequences of changing divergence patterns check that div_prev lags div_q by exactly one cycle.

// File: rtl/lockstep_div_mon.sv
module lockstep_div_mon #(
  parameter int NSIG  = 4,
  parameter int SW    = 8,
  parameter int NPORT = 2,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int TMO   = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSIG*SW-1:0]     st_a,
  input  logic [NSIG*SW-1:0]     st_b,
  input  logic [NPORT-1:0]       wv_a,
  input  logic [NPORT-1:0]       wv_b,
  input  logic [NPORT*AW-1:0]    wa_a,
  input  logic [NPORT*AW-1:0]    wa_b,
  input  logic [NPORT*DW-1:0]    wd_a,
  input  logic [NPORT*DW-1:0]    wd_b,
  input  logic                   term_a,
  input  logic                   term_b,
  output logic [NSIG+NPORT-1:0]  div_q,
  output logic [NSIG+NPORT-1:0]  div_prev,
  output logic                   done,
  output logic                   leak,
  output logic                   hang
);
  localparam int NV = NSIG + NPORT;
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [NV-1:0] div_now;

  genvar i;
  generate
    for (i = 0; i < NSIG; i++) begin : g_st
      assign div_now[i] = st_a[i*SW +: SW] != st_b[i*SW +: SW];
    end
    for (i = 0; i < NPORT; i++) begin : g_wp
      logic both;
      assign both = wv_a[i] & wv_b[i];
      assign div_now[NSIG+i] = (wv_a[i] ^ wv_b[i]) |
        (both & ((wa_a[i*AW +: AW] != wa_b[i*AW +: AW]) |
                 (wd_a[i*DW +: DW] != wd_b[i*DW +: DW])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      div_prev <= '0;
    end else begin
      div_q    <= div_now;
      div_prev <= div_q;
    end
  end

  logic          fin_a, fin_b, hang_q;
  logic [CW-1:0] cnt_a, cnt_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_a  <= 1'b0;
      fin_b  <= 1'b0;
      hang_q <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else if (!hang_q) begin
      if (!fin_a) begin
        cnt_a <= cnt_a + 1'b1;
        if (term_a) fin_a <= 1'b1;
      end
      if (!fin_b) begin
        cnt_b <= cnt_b + 1'b1;
        if (term_b) fin_b <= 1'b1;
      end
      if ((!fin_a && !term_a && cnt_a == LAST) ||
          (!fin_b && !term_b && cnt_b == LAST))
        hang_q <= 1'b1;
    end
  end

  assign hang = hang_q;
  assign done = (fin_a & fin_b) | hang_q;
  assign leak = fin_a & fin_b & (cnt_a != cnt_b);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r10_leak_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    leak |=> leak);
  a_r9_hang_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
    hang |-> !leak);
  a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    fin_a |=> $stable(cnt_a) && fin_a);
  a_r5_prev_lags: assert property (@(posedge clk) disable iff (!rst_n)
    div_prev == $past(div_q));
endmodule

// File: tb/lockstep_div_mon_tb.sv
module lockstep_div_mon_tb;
  localparam int NSIG = 4, SW = 8, NPORT = 2, AW = 5, DW = 32, CW = 16, TMO = 64;
  localparam int NV = NSIG + NPORT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSIG*SW-1:0] st_a = '0, st_b = '0;
  logic [NPORT-1:0] wv_a = '0, wv_b = '0;
  logic [NPORT*AW-1:0] wa_a = '0, wa_b = '0;
  logic [NPORT*DW-1:0] wd_a = '0, wd_b = '0;
  logic term_a = 1'b0, term_b = 1'b0;
  logic [NV-1:0] div_q, div_prev;
  logic done, leak, hang;

  int n_chk = 0, n_bad = 0;
  logic [NV-1:0] expq[$];
  string tagq[$];
  logic [NV-1:0] last_exp;
  bit had_prev = 0;

  always #10 clk = ~clk;

  lockstep_div_mon #(.NSIG(NSIG), .SW(SW), .NPORT(NPORT), .AW(AW), .DW(DW),
    .CW(CW), .TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_a(st_a), .st_b(st_b), .wv_a(wv_a), .wv_b(wv_b),
    .wa_a(wa_a), .wa_b(wa_b), .wd_a(wd_a), .wd_b(wd_b), .term_a(term_a),
    .term_b(term_b), .div_q(div_q), .div_prev(div_prev), .done(done),
    .leak(leak), .hang(hang));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic [NV-1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(div_q == e, t, div_q, e);
      if (had_prev) check(div_prev == last_exp, "R5 div_prev", div_prev, last_exp);
      had_prev = 1;
      last_exp = e;
    end else had_prev = 0;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    st_a = '0; st_b = '0; wv_a = '0; wv_b = '0;
    wa_a = '0; wa_b = '0; wd_a = '0; wd_b = '0;
    term_a = 1'b0; term_b = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_div(input logic [NSIG*SW-1:0] sa, input logic [NSIG*SW-1:0] sb,
      input logic [NPORT-1:0] va, input logic [NPORT-1:0] vb,
      input logic [NPORT*AW-1:0] aa, input logic [NPORT*AW-1:0] ab,
      input logic [NPORT*DW-1:0] da, input logic [NPORT*DW-1:0] db,
      input logic [NV-1:0] exp, input string tag);
    @(negedge clk);
    st_a = sa; st_b = sb; wv_a = va; wv_b = vb;
    wa_a = aa; wa_b = ab; wd_a = da; wd_b = db;
    expq.push_back(exp);
    tagq.push_back(tag);
  endtask

  // ta/tb: edge of first term pulse (0 = never); xa: extra pulse on copy A
  task automatic run_term(input int ta, input int tb, input int xa,
      input bit e_leak, input bit e_hang, input string tag);
    int fa, fb, lim;
    do_reset();
    fa = (ta == 0 || ta > TMO) ? 0 : ta;
    fb = (tb == 0 || tb > TMO) ? 0 : tb;
    lim = (fa == 0 || fb == 0) ? TMO + 3 : ((fa > fb ? fa : fb) + 3);
    for (int n = 1; n <= lim; n++) begin
      bit ed;
      ed = (fa != 0 && fb != 0 && fa <= n - 1 && fb <= n - 1) ||
           ((fa == 0 || fb == 0) && n - 1 >= TMO);
      if (n == 1 || n == lim || ed != done)
        check(done == ed, {tag, " R6 done timing"}, done, ed);
      term_a = (n == ta) || (n == xa);
      term_b = (n == tb);
      @(negedge clk);
    end
    term_a = 1'b0; term_b = 1'b0;
    check(done == 1'b1, {tag, " R10 done held"}, done, 1);
    check(leak == e_leak, {tag, " R7 leak"}, leak, e_leak);
    check(hang == e_hang, {tag, " R9 hang"}, hang, e_hang);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(div_q == 0 && div_prev == 0, "R1 reset div", {div_q, div_prev}, 0);
    check(done == 0 && leak == 0 && hang == 0, "R1 reset flags", {done, leak, hang}, 0);
    rst_n = 1'b1;
    #1;
    @(posedge clk); #1;
    check(div_q == 0 && div_prev == 0 && done == 0, "R1 first cycle",
          {div_q, div_prev, done}, 0);

    drive_div(32'h11223344, 32'h11223344, 2'b00, 2'b00, 10'h0, 10'h0, 64'h0, 64'h0, 6'b000000, "R2 equal");
    drive_div(32'h11223344, 32'h11AA3344, 2'b00, 2'b00, 10'h0, 10'h0, 64'h0, 64'h0, 6'b000100, "R2 slice2");
    drive_div(32'hFF000001, 32'h00000000, 2'b00, 2'b00, 10'h0, 10'h0, 64'h0, 64'h0, 6'b001001, "R2 slices0_3");
    drive_div(32'h0, 32'h0, 2'b01, 2'b00, 10'h0, 10'h0, 64'h0, 64'h0, 6'b010000, "R3 valid mismatch p0");
    drive_div(32'h0, 32'h0, 2'b00, 2'b10, 10'h0, 10'h0, 64'h0, 64'h0, 6'b100000, "R3 valid mismatch p1");
    drive_div(32'h0, 32'h0, 2'b11, 2'b11, 10'h3E0, 10'h3E0, 64'h5_00000000, 64'h6_00000000, 6'b100000, "R4 data p1");
    drive_div(32'h0, 32'h0, 2'b11, 2'b11, 10'h005, 10'h006, 64'h7, 64'h7, 6'b010000, "R4 addr p0");
    drive_div(32'h0, 32'h0, 2'b00, 2'b00, 10'h155, 10'h0AA, 64'hDEAD, 64'hBEEF, 6'b000000, "R4 idle ignored");
    drive_div(32'h0, 32'h0, 2'b11, 2'b11, 10'h21F, 10'h21F, 64'h1234_5678, 64'h1234_5678, 6'b000000, "R4 equal writes");
    drive_div(32'h1, 32'h2, 2'b11, 2'b01, 10'h0, 10'h0, 64'h0, 64'h1, 6'b110001, "R2 R3 R4 mixed");
    @(negedge clk);
    @(negedge clk);

    run_term(5, 5, 0, 1'b0, 1'b0, "equal");
    run_term(7, 12, 0, 1'b1, 1'b0, "differ");
    run_term(6, 9, 9, 1'b1, 1'b0, "R8 second pulse");
    run_term(TMO, 3, 0, 1'b1, 1'b0, "R9 limit edge");
    run_term(0, 10, 0, 1'b0, 1'b1, "R9 one hung");
    run_term(TMO + 1, 0, 0, 1'b0, 1'b1, "R9 both late");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule